// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, together with the current pixel column and line. It advances once for every cycle in which the pixel-rate enable is high. The frame geometry is held in a small register bank that software writes through a plain write/read port. The bank holds the sync pulse widths, the horizontal and vertical totals packed into one word, and the display-area start and end positions packed into one word per axis. These positions are absolute counts. The start is sync width plus back porch, the end is start plus active size, and the total is end plus front porch.

Software programs the geometry, clears the status word by writing zero, then writes the control word with the run bit set and the stop-request bit clear. Scanning begins at column 0, line 0, which is the leading edge of both sync pulses. To shut the panel down, software sets the stop-request bit and polls the status word. The generator finishes the frame in progress, returns to idle and raises the stopped flag. Timing words written while scanning is under way are held back until the next frame boundary, so a frame is never drawn with a mix of old and new geometry. Each sync and data-enable output can be inverted, and a configuration bit chooses the pixel-clock edge that the panel samples on.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset every register reads 0, the generator is idle, xPos and yPos are 0, and hsyncO, vsyncO, deO and pclkFallO are all 0.
- R2: Register map (word address: content). 0 control: bit0 run, bit1 stop request. 1 status: bit0 stopped. 2 polarity: bit0 active-low hsync, bit1 active-low vsync, bit2 active-low data enable, bit3 falling-edge pixel clock. 3 hsync width in bits 15:0. 4 vsync width in bits 15:0. 5 totals: horizontal in bits 31:16, vertical in bits 15:0. 6 horizontal area: start in 31:16, end in 15:0. 7 vertical area: same layout. Registers 0 and 2 to 7 read back what was written.
- R3: While scanning, xPos advances by one on each cycle with pixEn high. When xPos+1 reaches the horizontal total, xPos returns to 0 and yPos advances. When yPos+1 also reaches the vertical total, both return to 0. A cycle with pixEn low changes neither.
- R4: The raw hsync is active while scanning and xPos is below the hsync width. The raw vsync is active while scanning and yPos is below the vsync width.
- R5: The raw data enable is active while scanning with hStart <= xPos < hEnd and vStart <= yPos < vEnd.
- R6: Each polarity bit inverts its output: hsyncO, vsyncO, deO are the raw levels XOR bits 0, 1, 2. pclkFallO equals bit 3. Polarity changes apply in the cycle after the write.
- R7: From idle, with run=1 and stop request=0, scanning starts at the next clock edge with xPos=yPos=0, and xPos reads 1 one pixel later.
- R8: With the stop request set or the run bit clear, scanning continues until the last pixel of the frame completes. At that edge the generator goes idle with xPos=yPos=0 and status bit0 set. A control write that lands on that same last-pixel edge is seen only at the next frame's end.
- R9: A write to status with bit0=0 clears the stopped flag. A write with bit0=1 leaves it unchanged. The flag is set only by a completed stop.
- R10: The geometry in use is captured at start and at every frame end. Timing writes during a frame take effect at the next frame boundary. A write landing on the boundary edge itself waits for the following boundary.
- R11: Clearing the run bit without setting the stop request also stops the generator at the end of the frame and sets the stopped flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixEn | input | 1 | Pixel-rate enable, one pixel per high cycle |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| hsyncO | output | 1 | Horizontal sync after polarity |
| vsyncO | output | 1 | Vertical sync after polarity |
| deO | output | 1 | Data enable after polarity |
| pclkFallO | output | 1 | Pixel clock sampled on falling edge when 1 |
| xPos | output | 16 | Current column count |
| yPos | output | 16 | Current line count |

## Verification
Two pairs of functions can meet on one edge: a register write and the frame-boundary capture of timing, and a stop request and the last pixel of a frame. The bench waits on its own model until the next edge completes a frame with pixEn high, then lands a width write or a stop-request write on exactly that edge. The bench's model applies writes after the boundary decision, so it expects the write to miss that boundary. The comparison made every cycle then decides whether the design's outputs agree, frame by frame, with the one-frame delay.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 2 * CNT_W;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_POL    = 3'd2;
  localparam logic [ADDR_W-1:0] A_HSW    = 3'd3;
  localparam logic [ADDR_W-1:0] A_VSW    = 3'd4;
  localparam logic [ADDR_W-1:0] A_TOTAL  = 3'd5;
  localparam logic [ADDR_W-1:0] A_HAREA  = 3'd6;
  localparam logic [ADDR_W-1:0] A_VAREA  = 3'd7;

  typedef struct packed {
    logic [CNT_W-1:0] hSyncW;
    logic [CNT_W-1:0] vSyncW;
    logic [CNT_W-1:0] hTotal;
    logic [CNT_W-1:0] vTotal;
    logic [CNT_W-1:0] hStart;
    logic [CNT_W-1:0] hEnd;
    logic [CNT_W-1:0] vStart;
    logic [CNT_W-1:0] vEnd;
  } tgTiming_t;

  typedef struct packed {
    logic pclkFall;
    logic deLow;
    logic vsLow;
    logic hsLow;
  } tgPol_t;

  typedef struct packed {
    logic run;   // scanning is active
    logic load;  // zero counters and capture geometry this edge
  } tgStrobe_t;
endpackage

// File: rtl/lcd_tg_ctrl.sv
module lcd_tg_ctrl
  import lcd_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              frameEnd,
  output logic [DATA_W-1:0] regRdata,
  output tgTiming_t         liveTiming,
  output tgPol_t            pol,
  output tgStrobe_t         strobe
);
  logic runBit, stopReqBit, stopped, running;
  logic stopReq, startNow, stopNow;

  assign stopReq  = stopReqBit | ~runBit;
  assign startNow = ~running & runBit & ~stopReqBit;
  assign stopNow  = frameEnd & stopReq;
  assign strobe.run  = running;
  assign strobe.load = startNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit     <= 1'b0;
      stopReqBit <= 1'b0;
      pol        <= '0;
      liveTiming <= '0;
    end else if (regWe) begin
      unique case (regAddr)
        A_CTRL:  begin runBit <= regWdata[0]; stopReqBit <= regWdata[1]; end
        A_POL:   pol <= tgPol_t'(regWdata[3:0]);
        A_HSW:   liveTiming.hSyncW <= regWdata[CNT_W-1:0];
        A_VSW:   liveTiming.vSyncW <= regWdata[CNT_W-1:0];
        A_TOTAL: begin
          liveTiming.hTotal <= regWdata[DATA_W-1:CNT_W];
          liveTiming.vTotal <= regWdata[CNT_W-1:0];
        end
        A_HAREA: begin
          liveTiming.hStart <= regWdata[DATA_W-1:CNT_W];
          liveTiming.hEnd   <= regWdata[CNT_W-1:0];
        end
        A_VAREA: begin
          liveTiming.vStart <= regWdata[DATA_W-1:CNT_W];
          liveTiming.vEnd   <= regWdata[CNT_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      stopped <= 1'b0;
    end else begin
      if (startNow)     running <= 1'b1;
      else if (stopNow) running <= 1'b0;
      if (stopNow)
        stopped <= 1'b1;
      else if (regWe && regAddr == A_STATUS)
        stopped <= stopped & regWdata[0];
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_CTRL:   regRdata[1:0] = {stopReqBit, runBit};
      A_STATUS: regRdata[0]   = stopped;
      A_POL:    regRdata[3:0] = pol;
      A_HSW:    regRdata[CNT_W-1:0] = liveTiming.hSyncW;
      A_VSW:    regRdata[CNT_W-1:0] = liveTiming.vSyncW;
      A_TOTAL:  regRdata = {liveTiming.hTotal, liveTiming.vTotal};
      A_HAREA:  regRdata = {liveTiming.hStart, liveTiming.hEnd};
      A_VAREA:  regRdata = {liveTiming.vStart, liveTiming.vEnd};
      default:  regRdata = '0;
    endcase
  end

  // R8: scanning never ends except on a frame-end pixel
  a_r8_stop_only_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    (running && !frameEnd) |=> running);
  // R9: the stopped flag rises only with a completed stop
  a_r9_flag_set_by_stop_only: assert property (@(posedge clk) disable iff (!rstN)
    (!stopped && !(frameEnd && stopReq)) |=> !stopped);
  // R7: an idle generator with run set and no stop request starts next edge
  a_r7_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!running && runBit && !stopReqBit) |=> running);
endmodule

// File: rtl/lcd_tg_datapath.sv
module lcd_tg_datapath
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  tgStrobe_t        strobe,
  input  tgTiming_t        liveTiming,
  input  tgPol_t           pol,
  output logic             frameEnd,
  output logic             hsyncO,
  output logic             vsyncO,
  output logic             deO,
  output logic             pclkFallO,
  output logic [CNT_W-1:0] xPos,
  output logic [CNT_W-1:0] yPos
);
  localparam int N_OUT = 3;

  tgTiming_t        shadow;
  logic [CNT_W-1:0] xCnt, yCnt;
  logic             lastX, lastY;
  logic [N_OUT-1:0] rawSig, invSig, outSig;

  assign lastX    = ({1'b0, xCnt} + 1'b1) >= {1'b0, shadow.hTotal};
  assign lastY    = ({1'b0, yCnt} + 1'b1) >= {1'b0, shadow.vTotal};
  assign frameEnd = strobe.run & pixEn & lastX & lastY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt   <= '0;
      yCnt   <= '0;
      shadow <= '0;
    end else if (strobe.load) begin
      xCnt   <= '0;
      yCnt   <= '0;
      shadow <= liveTiming;
    end else if (strobe.run && pixEn) begin
      if (lastX) begin
        xCnt <= '0;
        if (lastY) begin
          yCnt   <= '0;
          shadow <= liveTiming;
        end else begin
          yCnt <= yCnt + 1'b1;
        end
      end else begin
        xCnt <= xCnt + 1'b1;
      end
    end
  end

  assign rawSig[0] = strobe.run & (xCnt < shadow.hSyncW);
  assign rawSig[1] = strobe.run & (yCnt < shadow.vSyncW);
  assign rawSig[2] = strobe.run & (xCnt >= shadow.hStart) & (xCnt < shadow.hEnd)
                                & (yCnt >= shadow.vStart) & (yCnt < shadow.vEnd);
  assign invSig = {pol.deLow, pol.vsLow, pol.hsLow};

  for (genvar i = 0; i < N_OUT; i++) begin : g_pol
    assign outSig[i] = rawSig[i] ^ invSig[i];
  end

  assign hsyncO    = outSig[0];
  assign vsyncO    = outSig[1];
  assign deO       = outSig[2];
  assign pclkFallO = pol.pclkFall;
  assign xPos      = xCnt;
  assign yPos      = yCnt;

  // R3: counters hold when no pixel is due and no start occurs
  a_r3_hold_without_pixel: assert property (@(posedge clk) disable iff (!rstN)
    (!pixEn && !strobe.load) |=> ($stable(xCnt) && $stable(yCnt)));
  // R3: the column stays below a nonzero captured total
  a_r3_x_below_total: assert property (@(posedge clk) disable iff (!rstN)
    (shadow.hTotal != '0) |-> (xCnt < shadow.hTotal));
  // R10: captured geometry changes only at start or frame end
  a_r10_shadow_held_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (!frameEnd && !strobe.load) |=> $stable(shadow));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              hsyncO,
  output logic              vsyncO,
  output logic              deO,
  output logic              pclkFallO,
  output logic [CNT_W-1:0]  xPos,
  output logic [CNT_W-1:0]  yPos
);
  tgTiming_t liveTiming;
  tgPol_t    pol;
  tgStrobe_t strobe;
  logic      frameEnd;

  lcd_tg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .frameEnd(frameEnd), .regRdata(regRdata),
    .liveTiming(liveTiming), .pol(pol), .strobe(strobe)
  );

  lcd_tg_datapath u_dp (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .strobe(strobe),
    .liveTiming(liveTiming), .pol(pol), .frameEnd(frameEnd),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .pclkFallO(pclkFallO),
    .xPos(xPos), .yPos(yPos)
  );
endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixEn = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        hsyncO, vsyncO, deO, pclkFallO;
  logic [15:0] xPos, yPos;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int pixMode = 0;
  int pixCnt = 0;
  bit done = 0;

  // behavioural model state
  int mHsw, mVsw, mHt, mVt, mHs, mHe, mVs, mVe;
  int sHsw, sVsw, sHt, sVt, sHs, sHe, sVs, sVe;
  int mCfg, mEn, mDis, mRun, mStop, mX, mY;
  bit stopEv;

  always #4 clk = ~clk;

  lcd_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hsyncO(hsyncO), .vsyncO(vsyncO),
    .deO(deO), .pclkFallO(pclkFallO), .xPos(xPos), .yPos(yPos)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic capture();
    sHsw = mHsw; sVsw = mVsw; sHt = mHt; sVt = mVt;
    sHs = mHs; sHe = mHe; sVs = mVs; sVe = mVe;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mHsw = 0; mVsw = 0; mHt = 0; mVt = 0; mHs = 0; mHe = 0; mVs = 0; mVe = 0;
      capture();
      mCfg = 0; mEn = 0; mDis = 0; mRun = 0; mStop = 0; mX = 0; mY = 0;
    end else begin
      stopEv = 0;
      if (!mRun) begin
        if (mEn && !mDis) begin mRun = 1; mX = 0; mY = 0; capture(); end
      end else if (pixEn) begin
        if (mX + 1 >= sHt) begin
          mX = 0;
          if (mY + 1 >= sVt) begin
            mY = 0; capture();
            if (mDis || !mEn) begin mRun = 0; stopEv = 1; end
          end else mY = mY + 1;
        end else mX = mX + 1;
      end
      if (regWe) begin
        case (regAddr)
          3'd0: begin mEn = regWdata[0]; mDis = regWdata[1]; end
          3'd1: mStop = mStop & regWdata[0];
          3'd2: mCfg = regWdata[3:0];
          3'd3: mHsw = regWdata[15:0];
          3'd4: mVsw = regWdata[15:0];
          3'd5: begin mHt = regWdata[31:16]; mVt = regWdata[15:0]; end
          3'd6: begin mHs = regWdata[31:16]; mHe = regWdata[15:0]; end
          default: begin mVs = regWdata[31:16]; mVe = regWdata[15:0]; end
        endcase
      end
      if (stopEv) mStop = 1;
    end
  end

  // pixel enable pattern
  always @(negedge clk) begin
    pixCnt++;
    pixEn = (pixMode == 0) ? 1'b1 : (pixCnt % 3 == 0);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R3 xPos", xPos, mX);
      chk("R3 yPos", yPos, mY);
      chk("R4 hsyncO", hsyncO, (mRun && mX < sHsw) ^ mCfg[0]);
      chk("R4 vsyncO", vsyncO, (mRun && mY < sVsw) ^ mCfg[1]);
      chk("R5 deO", deO, (mRun && mX >= sHs && mX < sHe && mY >= sVs && mY < sVe) ^ mCfg[2]);
      chk("R6 pclkFallO", pclkFallO, mCfg[3]);
    end
  end

  task automatic wrReg(input int a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a[2:0]; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input int a, input int exp);
    regAddr = a[2:0];
    #1;
    chk(tag, regRdata, exp);
  endtask

  task automatic waitLastPixel();
    do @(negedge clk); while (!(mRun && mX + 1 >= sHt && mY + 1 >= sVt));
  endtask

  task automatic waitStop(output int n);
    n = 0;
    regAddr = 3'd1;
    #1;
    while (!regRdata[0] && n < 2000) begin
      @(negedge clk);
      regAddr = 3'd1;
      #1;
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rdChk("R1 register after reset", a, 0);
    chk("R1 hsyncO", hsyncO, 0); chk("R1 deO", deO, 0);
    chk("R1 xPos", xPos, 0); chk("R1 pclkFallO", pclkFallO, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    wrReg(3, 2); wrReg(4, 1);
    wrReg(5, (12 << 16) | 8);
    wrReg(6, (4 << 16) | 10);
    wrReg(7, (2 << 16) | 6);
    rdChk("R2 totals readback", 5, (12 << 16) | 8);
    rdChk("R2 horizontal area readback", 6, (4 << 16) | 10);
    rdChk("R2 hsync width readback", 3, 2);
    wrReg(1, 0);
    wrReg(0, 1);
    rdChk("R2 control readback", 0, 1);
    repeat (2) @(negedge clk);
    #1 chk("R7 first column after start", xPos, 1);
    repeat (200) @(negedge clk);
    pixMode = 1;
    repeat (300) @(negedge clk);
    pixMode = 0;
    @(negedge clk);
    // R6 polarity
    wrReg(2, 32'hF);
    #1 chk("R6 falling-edge select", pclkFallO, 1);
    repeat (100) @(negedge clk);
    wrReg(2, 32'h5);
    repeat (50) @(negedge clk);
    wrReg(2, 0);
    // R10 geometry change mid frame and on the boundary edge
    repeat (17) @(negedge clk);
    wrReg(5, (10 << 16) | 6);
    wrReg(3, 3);
    wrReg(6, (3 << 16) | 8);
    wrReg(7, (1 << 16) | 5);
    repeat (150) @(negedge clk);
    waitLastPixel();
    wrReg(3, 1);
    #1 chk("R10 boundary write waits a frame", xPos, 0);
    repeat (150) @(negedge clk);
    // R8 stop mid frame
    repeat (7) @(negedge clk);
    wrReg(0, 3);
    rdChk("R8 no stop before frame end", 1, 0);
    waitStop(n);
    chk("R8 stop completes", regRdata[0], 1);
    chk("R8 idle column", xPos, 0);
    chk("R8 idle line", yPos, 0);
    chk("R8 idle data enable", deO, 0);
    // R9 status clear semantics
    @(negedge clk);
    wrReg(1, 1);
    rdChk("R9 writing one keeps flag", 1, 1);
    wrReg(1, 0);
    rdChk("R9 writing zero clears flag", 1, 0);
    wrReg(0, 1);
    repeat (100) @(negedge clk);
    // R8 stop request landing on the last pixel
    waitLastPixel();
    wrReg(0, 3);
    rdChk("R8 boundary request not yet stopped", 1, 0);
    waitStop(n);
    chk("R8 boundary request runs one more frame", (n >= 55) ? 1 : 0, 1);
    // R11 run bit cleared
    @(negedge clk);
    wrReg(1, 0);
    wrReg(0, 1);
    repeat (80) @(negedge clk);
    wrReg(0, 0);
    rdChk("R11 still scanning", 1, 0);
    waitStop(n);
    chk("R11 stop via run bit", regRdata[0], 1);
    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule